// File: doc/BRIEF.md
# Key-locked control register bank

This block is a 4 KB window of 32-bit control and status words behind a single-cycle word bus. A request presents a byte address, a write flag and write data. The answer comes in the next cycle, with read data and an error flag. The window is indexed by word (byte address divided by four), and every word index belongs to one access class: read-write, read-only, write-only or unmapped.

Most read-write words are protected by a lock that is closed after reset. Software opens the lock by writing a 16-bit key to one write-only word and closes it with a second key at another. While the lock is closed, writes to protected words are dropped without any error. The word at offset 0x000 is an exception: it can always be written and keeps only bit 0. An accepted write that sets bit 0 of the reset-control word sends a one-cycle system reset request out of the block.

Top module: `sysreg_bank`

## Requirements
- R1: After reset the lock is closed. The lock-status word (0x00C) reads 1, the reset-reason word (0x250) reads 0x40, the PLL-status word (0x10C) reads 0x3F and the boot-mode word (0x25C) reads 0x1. While no request is made, ready, err and sys_rst_req are low.
- R2: Every request is answered exactly one cycle later, with ready high and with rdata and err valid in that same cycle. A cycle without a request is followed by ready low.
- R3: A write to the unlock word (0x008) opens the lock only when wdata[15:0] equals 0xDF0D. wdata[31:16] is ignored, and any other low half leaves the lock unchanged.
- R4: A write to the lock word (0x004) closes the lock only when wdata[15:0] equals 0x767B. Any other value leaves the lock unchanged.
- R5: While the lock is closed, writes to protected read-write words (every read-write word except 0x000) are dropped. They raise no error.
- R6: The word at 0x000 accepts writes whether the lock is open or closed. It stores wdata[0] only, and bits 31:1 read as zero.
- R7: The access classes are as follows.
  - Write-only: 0x004, 0x008, 0x60C and 0x614.
  - Read-only: 0x00C, 0x10C, 0x25C, 0x530, 0x618 and 0x61C.
  - Read-write: 0x000, 0x100–0x13C except 0x10C, 0x200–0x244, 0x250 and 0x700–0x7D4.
  - Unmapped: every other word.
  A read of a write-only word, a write to a read-only word, and any access to an unmapped word each raise err with the response. Such writes change nothing, and such reads return zero.
- R8: An unlocked write to the reset-control word (0x200) with wdata[0]=1 raises sys_rst_req in the response cycle. A write that is locked, or that has bit 0 clear, raises no request.
- R9: With the lock open, a write to a read-write word stores all 32 bits, and a later read returns them.
- R10: The ID word (0x530) is read-only and returns the ID_CODE parameter.
- R11: The lock-status word reads 0 while the lock is open and 1 while it is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (12) | Byte address inside the window |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid with ready |
| ready | output | 1 | Response strobe, one cycle after req |
| err | output | 1 | Illegal access flag, valid with ready |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the bank with its default 12-bit address and 32-bit data widths, so every word of the 4 KB window can be addressed, including the ends of the pin-configuration range and the unmapped gaps. The ID_CODE parameter is overridden with a value that is neither zero nor the default. A read that returns it therefore shows that the read-only word follows the parameter. The default key values are kept, so near-miss keys one count away from the real ones can be tried against both the lock word and the unlock word.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO, ACC_NONE} acc_e;

  typedef enum logic [2:0] {
    SRC_RAM, SRC_ZERO, SRC_CTRL0, SRC_LOCKSTA,
    SRC_PLL, SRC_BOOT, SRC_ID, SRC_REASON
  } src_e;

  typedef struct packed {
    acc_e acc;
    src_e src;
    logic free_wr;
    logic is_lock;
    logic is_unlock;
    logic is_rstctl;
  } dec_t;

  // word indices (byte offset / 4)
  localparam int unsigned W_CTRL0   = 0;
  localparam int unsigned W_LOCK    = 1;
  localparam int unsigned W_UNLOCK  = 2;
  localparam int unsigned W_LOCKSTA = 3;
  localparam int unsigned W_CLK_LO  = 64;
  localparam int unsigned W_PLLSTA  = 67;
  localparam int unsigned W_CLK_HI  = 79;
  localparam int unsigned W_RSTCTL  = 128;
  localparam int unsigned W_RST_HI  = 145;
  localparam int unsigned W_REASON  = 148;
  localparam int unsigned W_BOOT    = 151;
  localparam int unsigned W_ID      = 332;
  localparam int unsigned W_CAL     = 387;
  localparam int unsigned W_REF     = 389;
  localparam int unsigned W_DDRSTA  = 390;
  localparam int unsigned W_DFISTA  = 391;
  localparam int unsigned W_PIN_LO  = 448;
  localparam int unsigned W_PIN_HI  = 501;

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);

  int unsigned w;

  always_comb begin
    w   = 32'(idx);
    dec = '{acc: ACC_NONE, src: SRC_ZERO, free_wr: 1'b0,
            is_lock: 1'b0, is_unlock: 1'b0, is_rstctl: 1'b0};
    if (w == W_CTRL0) begin
      dec.acc = ACC_RW; dec.src = SRC_CTRL0; dec.free_wr = 1'b1;
    end else if (w == W_LOCK) begin
      dec.acc = ACC_WO; dec.is_lock = 1'b1;
    end else if (w == W_UNLOCK) begin
      dec.acc = ACC_WO; dec.is_unlock = 1'b1;
    end else if (w == W_LOCKSTA) begin
      dec.acc = ACC_RO; dec.src = SRC_LOCKSTA;
    end else if (w == W_PLLSTA) begin
      dec.acc = ACC_RO; dec.src = SRC_PLL;
    end else if (w >= W_CLK_LO && w <= W_CLK_HI) begin
      dec.acc = ACC_RW; dec.src = SRC_RAM;
    end else if (w == W_RSTCTL) begin
      dec.acc = ACC_RW; dec.src = SRC_RAM; dec.is_rstctl = 1'b1;
    end else if (w > W_RSTCTL && w <= W_RST_HI) begin
      dec.acc = ACC_RW; dec.src = SRC_RAM;
    end else if (w == W_REASON) begin
      dec.acc = ACC_RW; dec.src = SRC_REASON;
    end else if (w == W_BOOT) begin
      dec.acc = ACC_RO; dec.src = SRC_BOOT;
    end else if (w == W_ID) begin
      dec.acc = ACC_RO; dec.src = SRC_ID;
    end else if (w == W_CAL || w == W_REF) begin
      dec.acc = ACC_WO;
    end else if (w == W_DDRSTA || w == W_DFISTA) begin
      dec.acc = ACC_RO;
    end else if (w >= W_PIN_LO && w <= W_PIN_HI) begin
      dec.acc = ACC_RW; dec.src = SRC_RAM;
    end
  end

endmodule

// File: rtl/sysreg_lock.sv
module sysreg_lock #(
  parameter int unsigned     KEY_W      = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lock,
  input  logic             wr_unlock,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
    end else if (wr_unlock && key == UNLOCK_KEY) begin
      locked <= 1'b0;
    end else if (wr_lock && key == LOCK_KEY) begin
      locked <= 1'b1;
    end
  end

  AST_LOCK_MOVES_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (rst)
    !$stable(locked) |-> $past(wr_lock || wr_unlock)); // R3
  AST_UNLOCK_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (wr_unlock && key == UNLOCK_KEY) |=> !locked); // R3
  AST_LOCK_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && key == LOCK_KEY) |=> locked); // R4

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       KEY_W       = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY    = 16'h767B,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hDF0D,
  parameter logic [DATA_W-1:0] ID_CODE     = 32'h0372_C093,
  parameter logic [DATA_W-1:0] PLL_STAT    = 32'h0000_003F,
  parameter logic [DATA_W-1:0] BOOT_MODE   = 32'h0000_0001,
  parameter logic [DATA_W-1:0] REASON_INIT = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              err,
  output logic              sys_rst_req
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  dec_t             dec;
  logic             wr, rd, wr_ok, rd_ok, commit, locked;
  logic [DATA_W-1:0] ram_rd;
  logic             ctrl0_q;
  logic [DATA_W-1:0] reason_q;
  src_e             src_q;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  sysreg_decode #(.IDX_W(IDX_W)) u_dec (.idx(idx), .dec(dec));

  assign wr     = req && we;
  assign rd     = req && !we;
  assign wr_ok  = dec.acc == ACC_RW || dec.acc == ACC_WO;
  assign rd_ok  = dec.acc == ACC_RW || dec.acc == ACC_RO;
  assign commit = wr && dec.acc == ACC_RW && (dec.free_wr || !locked);

  sysreg_lock #(.KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst(rst),
    .wr_lock(wr && dec.is_lock), .wr_unlock(wr && dec.is_unlock),
    .key(wdata[KEY_W-1:0]), .locked(locked)
  );

  sysreg_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(commit && dec.src == SRC_RAM), .re(rd && dec.src == SRC_RAM),
    .idx(idx), .wdata(wdata), .rdata(ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0_q     <= 1'b0;
      reason_q    <= REASON_INIT;
      ready       <= 1'b0;
      err         <= 1'b0;
      sys_rst_req <= 1'b0;
      src_q       <= SRC_ZERO;
    end else begin
      if (commit && dec.src == SRC_CTRL0)  ctrl0_q  <= wdata[0];
      if (commit && dec.src == SRC_REASON) reason_q <= wdata;
      ready       <= req;
      err         <= req && (we ? !wr_ok : !rd_ok);
      sys_rst_req <= commit && dec.is_rstctl && wdata[0];
      src_q       <= (rd && rd_ok) ? dec.src : SRC_ZERO;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM:     rdata = ram_rd;
      SRC_CTRL0:   rdata = {{(DATA_W-1){1'b0}}, ctrl0_q};
      SRC_LOCKSTA: rdata = {{(DATA_W-1){1'b0}}, locked};
      SRC_PLL:     rdata = PLL_STAT;
      SRC_BOOT:    rdata = BOOT_MODE;
      SRC_ID:      rdata = ID_CODE;
      SRC_REASON:  rdata = reason_q;
      default:     rdata = '0;
    endcase
  end

  AST_LOCKED_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> locked); // R1
  AST_READY_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req |=> ready); // R2
  AST_NO_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ready); // R2
  AST_ERR_WITH_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    err |-> ready); // R7
  AST_RESET_REQ_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(req && we && !locked)); // R8

endmodule

// File: tb/test_sysreg_bank.sv
module test_sysreg_bank;

  localparam logic [31:0] ID = 32'h2468_ACE1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, err, sys_rst_req;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sysreg_bank #(.ID_CODE(ID)) i_sysreg_bank (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .err(err), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] r, output logic e, output logic p, output logic rdy);
    @(negedge clk); req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #1; r = rdata; e = err; p = sys_rst_req; rdy = ready;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input logic exp_err, input string tag);
    logic [31:0] r; logic e, p, y;
    bus(1'b0, a, '0, r, e, p, y);
    chk({tag, " rdata"}, r, exp);
    chk({tag, " err"}, 32'(e), 32'(exp_err));
  endtask

  task automatic wr_chk(input logic [11:0] a, input logic [31:0] d, input logic exp_err,
                        input logic exp_pulse, input string tag);
    logic [31:0] r; logic e, p, y;
    bus(1'b1, a, d, r, e, p, y);
    chk({tag, " err"}, 32'(e), 32'(exp_err));
    chk({tag, " sys_rst_req"}, 32'(p), 32'(exp_pulse));
  endtask

  task automatic t_reset;
    chk("R1 idle ready", 32'(ready), 0);
    chk("R1 idle err", 32'(err), 0);
    chk("R1 idle sys_rst_req", 32'(sys_rst_req), 0);
    rd_chk(12'h00C, 32'h1, 1'b0, "R1 lock status");
    rd_chk(12'h250, 32'h40, 1'b0, "R1 reset reason");
    rd_chk(12'h10C, 32'h3F, 1'b0, "R1 pll status");
    rd_chk(12'h25C, 32'h1, 1'b0, "R1 boot mode");
    rd_chk(12'h530, ID, 1'b0, "R10 id code");
  endtask

  task automatic t_timing;
    logic [31:0] r; logic e, p, y;
    bus(1'b0, 12'h00C, '0, r, e, p, y);
    chk("R2 ready with response", 32'(y), 1);
    @(posedge clk); #1;
    chk("R2 no ready after idle", 32'(ready), 0);
    bus(1'b1, 12'h800, 32'h5, r, e, p, y);
    chk("R2 ready on write", 32'(y), 1);
  endtask

  task automatic t_keys;
    wr_chk(12'h008, 32'h0000_DF0C, 1'b0, 1'b0, "R3 wrong unlock key");
    rd_chk(12'h00C, 32'h1, 1'b0, "R3 still locked");
    wr_chk(12'h008, 32'hFFFF_DF0D, 1'b0, 1'b0, "R3 unlock upper ignored");
    rd_chk(12'h00C, 32'h0, 1'b0, "R11 reads open");
    wr_chk(12'h004, 32'h0000_767A, 1'b0, 1'b0, "R4 wrong lock key");
    rd_chk(12'h00C, 32'h0, 1'b0, "R4 still open");
    wr_chk(12'h004, 32'h0000_767B, 1'b0, 1'b0, "R4 lock key");
    rd_chk(12'h00C, 32'h1, 1'b0, "R4 closed");
  endtask

  task automatic t_ctrl0;
    wr_chk(12'h000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 locked write");
    rd_chk(12'h000, 32'h1, 1'b0, "R6 bit0 only");
    wr_chk(12'h000, 32'h0000_0002, 1'b0, 1'b0, "R6 bit0 clear");
    rd_chk(12'h000, 32'h0, 1'b0, "R6 cleared");
  endtask

  task automatic t_store_and_lock;
    wr_chk(12'h008, 32'h0000_DF0D, 1'b0, 1'b0, "R9 unlock");
    wr_chk(12'h104, 32'hA5A5_1234, 1'b0, 1'b0, "R9 write clk word");
    wr_chk(12'h700, 32'h0000_1601, 1'b0, 1'b0, "R9 write pin first");
    wr_chk(12'h7D4, 32'hDEAD_BEEF, 1'b0, 1'b0, "R9 write pin last");
    wr_chk(12'h250, 32'h0000_0011, 1'b0, 1'b0, "R9 write reason");
    rd_chk(12'h104, 32'hA5A5_1234, 1'b0, "R9 read clk word");
    rd_chk(12'h700, 32'h0000_1601, 1'b0, "R9 read pin first");
    rd_chk(12'h7D4, 32'hDEAD_BEEF, 1'b0, "R9 read pin last");
    rd_chk(12'h250, 32'h0000_0011, 1'b0, "R9 read reason");
    wr_chk(12'h004, 32'h0000_767B, 1'b0, 1'b0, "R5 relock");
    wr_chk(12'h104, 32'h0BAD_0BAD, 1'b0, 1'b0, "R5 locked write no err");
    wr_chk(12'h250, 32'h0000_0099, 1'b0, 1'b0, "R5 locked reason write");
    rd_chk(12'h104, 32'hA5A5_1234, 1'b0, "R5 word kept");
    rd_chk(12'h250, 32'h0000_0011, 1'b0, "R5 reason kept");
  endtask

  task automatic t_classes;
    wr_chk(12'h008, 32'h0000_DF0D, 1'b0, 1'b0, "R7 unlock");
    wr_chk(12'h10C, 32'h0000_0000, 1'b1, 1'b0, "R7 write read-only pll");
    rd_chk(12'h10C, 32'h3F, 1'b0, "R7 pll unchanged");
    wr_chk(12'h530, 32'h1111_1111, 1'b1, 1'b0, "R7 write read-only id");
    rd_chk(12'h530, ID, 1'b0, "R10 id unchanged");
    wr_chk(12'h00C, 32'h1, 1'b1, 1'b0, "R7 write lock status");
    rd_chk(12'h00C, 32'h0, 1'b0, "R7 lock status unchanged");
    rd_chk(12'h004, 32'h0, 1'b1, "R7 read write-only lock");
    rd_chk(12'h60C, 32'h0, 1'b1, "R7 read write-only cal");
    wr_chk(12'h614, 32'h1, 1'b0, 1'b0, "R7 write write-only ref");
    rd_chk(12'h618, 32'h0, 1'b0, "R7 read-only ddr status");
    rd_chk(12'h800, 32'h0, 1'b1, "R7 read unmapped");
    wr_chk(12'h7D8, 32'h1234_5678, 1'b1, 1'b0, "R7 write unmapped past pins");
    rd_chk(12'h7D8, 32'h0, 1'b1, "R7 unmapped still zero");
  endtask

  task automatic t_soft_reset;
    wr_chk(12'h200, 32'h0000_0001, 1'b0, 1'b1, "R8 unlocked soft reset");
    @(posedge clk); #1;
    chk("R8 pulse single cycle", 32'(sys_rst_req), 0);
    wr_chk(12'h200, 32'h0000_0002, 1'b0, 1'b0, "R8 bit0 clear no pulse");
    wr_chk(12'h004, 32'h0000_767B, 1'b0, 1'b0, "R8 relock");
    wr_chk(12'h200, 32'h0000_0001, 1'b0, 1'b0, "R8 locked no pulse");
    rd_chk(12'h200, 32'h0000_0002, 1'b0, "R5 reset word kept");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_timing();
    t_keys();
    t_ctrl0();
    t_store_and_lock();
    t_classes();
    t_soft_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule